// File: doc/BRIEF.md
# Network Address Offset Translator

This block sits between a node's local shared memory and a ring-style network that carries byte addresses in a 256 MByte space (28 address bits). A 2-bit offset selector shifts the window of the network space that the node's memory occupies, in steps of 64 MByte. When the host writes, the write goes to local memory at its own address and out to the network with the offset added. When a packet arrives and is to be stored locally, the offset is removed. A packet that only passes through the node toward the next one is handed on with its address untouched.

Address arithmetic is modulo 2^28, so any sum that crosses the top of the network space wraps to a low address. The installed-memory configuration code sets how much local memory exists. Every local store, whether a host write or a received packet, is range-checked against that size after translation. A store that falls outside the memory is flagged and not marked valid. Each request path has one register stage. The offset and configuration are sampled in the cycle in which a request is accepted.

Top module: `net_ofs_xlate`

## Requirements
- R1: While reset is high, every valid strobe and out-of-range flag is 0, even when requests are asserted.
- R2: A host write accepted at a clock edge raises net_vld_o for one cycle after that edge, with net_addr_o = (tx_addr_i + ofs_sel_i * 0x4000000) mod 2^28. The upper offset bit adds to A27 and the lower offset bit adds to A26.
- R3: When the address plus the offset reaches or exceeds 0x10000000, the bits above A27 are dropped. For example, 0xFFFFFF0 with offset 1 gives 0x3FFFFF0.
- R4: The local side of a host write uses the untranslated address: hwr_addr_o equals tx_addr_i whatever the offset.
- R5: A received packet gives rx_addr_o = (rx_addr_i - ofs_sel_i * 0x4000000) mod 2^28 one cycle after it is accepted.
- R6: A forwarded packet appears on fwd_addr_o unchanged one cycle later, with fwd_vld_o high, whatever the offset and configuration.
- R7: The configuration code mem_cfg_i gives the installed size: 00 = 64 MByte (limit 0x4000000), 01 = 128 MByte (limit 0x8000000), 10 = 256 MByte (no limit). A local address at or above the limit raises the matching out-of-range flag (hwr_oor_o or rx_oor_o) instead of its valid strobe.
- R8: Configuration code 11 is reserved, and every local store made under it is flagged out-of-range.
- R9: The offset is sampled when a request is accepted. With no new request, the output addresses hold and the valid strobes fall, even if ofs_sel_i changes.
- R10: A host write translated with some offset and then received with the same offset reproduces the original local address.
- R11: Host write, receive and forward requests in the same cycle are all served independently in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ofs_sel_i | input | 2 | Offset step selector (64 MByte units) |
| mem_cfg_i | input | 2 | Installed-memory size code |
| tx_req_i | input | 1 | Host write request |
| tx_addr_i | input | 28 | Host write local address |
| rx_req_i | input | 1 | Received packet to be stored locally |
| rx_addr_i | input | 28 | Network address of received packet |
| fwd_req_i | input | 1 | Pass-through packet request |
| fwd_addr_i | input | 28 | Network address of pass-through packet |
| net_vld_o | output | 1 | Outgoing network address valid |
| net_addr_o | output | 28 | Offset-added network address |
| hwr_vld_o | output | 1 | Host local write in range |
| hwr_oor_o | output | 1 | Host local write out of range |
| hwr_addr_o | output | 28 | Host local write address (untranslated) |
| rx_vld_o | output | 1 | Received store in range |
| rx_oor_o | output | 1 | Received store out of range |
| rx_addr_o | output | 28 | Offset-removed local address |
| fwd_vld_o | output | 1 | Forwarded packet valid |
| fwd_addr_o | output | 28 | Forwarded address, unchanged |

## Verification
The bench builds the block with its default parameters: a 28-bit network address, a 2-bit offset, and a 64 MByte base memory size. At these values all four offset steps and all four configuration codes are cheap to enumerate. The vector table covers every offset step, the wrap at the top of the space on both add and subtract, and the address just below and just at each memory-size limit. Directed cases then cover reset with requests asserted, holding the outputs while the offset changes, a transmit-then-receive round trip, and all three request kinds arriving in one cycle.

// File: rtl/nat_pkg.sv
package nat_pkg;
  localparam int CFG_W = 2;

  typedef enum logic [CFG_W-1:0] {
    CFG_SZ_64M  = 2'b00,
    CFG_SZ_128M = 2'b01,
    CFG_SZ_256M = 2'b10,
    CFG_SZ_RSVD = 2'b11
  } mem_cfg_e;

  function automatic logic cfg_is_reserved(input logic [CFG_W-1:0] cfg);
    return mem_cfg_e'(cfg) == CFG_SZ_RSVD;
  endfunction
endpackage

// File: rtl/nat_ofs_add.sv
module nat_ofs_add #(
  parameter int AW  = 28,
  parameter int OW  = 2,
  parameter bit SUB = 1'b0
) (
  input  logic [AW-1:0] addr_i,
  input  logic [OW-1:0] ofs_i,
  output logic [AW-1:0] addr_o
);
  localparam int LW = AW - OW;

  logic [OW-1:0] hi;

  // Only the top OW bits move; carry out of the top bit is dropped (wrap).
  generate
    if (SUB) begin : g_sub
      assign hi = addr_i[AW-1:LW] - ofs_i;
    end else begin : g_add
      assign hi = addr_i[AW-1:LW] + ofs_i;
    end
  endgenerate

  assign addr_o = {hi, addr_i[LW-1:0]};
endmodule

// File: rtl/nat_range_chk.sv
module nat_range_chk
  import nat_pkg::*;
#(
  parameter int AW       = 28,
  parameter int BASE_LG2 = 26
) (
  input  logic [AW-1:0]    addr_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic             ok_o
);
  logic [AW-1:0] above;
  int            lim_lg2;

  always_comb begin
    lim_lg2 = BASE_LG2 + int'(cfg_i);
    above   = addr_i >> lim_lg2;
    ok_o    = !cfg_is_reserved(cfg_i) && (above == '0);
  end
endmodule

// File: rtl/net_ofs_xlate.sv
module net_ofs_xlate
  import nat_pkg::*;
#(
  parameter int NET_AW   = 28,
  parameter int OFS_W    = 2,
  parameter int BASE_LG2 = 26
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OFS_W-1:0]    ofs_sel_i,
  input  logic [CFG_W-1:0]    mem_cfg_i,
  input  logic                tx_req_i,
  input  logic [NET_AW-1:0]   tx_addr_i,
  input  logic                rx_req_i,
  input  logic [NET_AW-1:0]   rx_addr_i,
  input  logic                fwd_req_i,
  input  logic [NET_AW-1:0]   fwd_addr_i,
  output logic                net_vld_o,
  output logic [NET_AW-1:0]   net_addr_o,
  output logic                hwr_vld_o,
  output logic                hwr_oor_o,
  output logic [NET_AW-1:0]   hwr_addr_o,
  output logic                rx_vld_o,
  output logic                rx_oor_o,
  output logic [NET_AW-1:0]   rx_addr_o,
  output logic                fwd_vld_o,
  output logic [NET_AW-1:0]   fwd_addr_o
);
  localparam int LW = NET_AW - OFS_W;

  logic [NET_AW-1:0] tx_net, rx_loc;
  logic              hwr_ok, rx_ok;

  nat_ofs_add #(.AW(NET_AW), .OW(OFS_W), .SUB(1'b0)) u_tx_add (
    .addr_i(tx_addr_i), .ofs_i(ofs_sel_i), .addr_o(tx_net));

  nat_ofs_add #(.AW(NET_AW), .OW(OFS_W), .SUB(1'b1)) u_rx_sub (
    .addr_i(rx_addr_i), .ofs_i(ofs_sel_i), .addr_o(rx_loc));

  nat_range_chk #(.AW(NET_AW), .BASE_LG2(BASE_LG2)) u_hwr_chk (
    .addr_i(tx_addr_i), .cfg_i(mem_cfg_i), .ok_o(hwr_ok));

  nat_range_chk #(.AW(NET_AW), .BASE_LG2(BASE_LG2)) u_rx_chk (
    .addr_i(rx_loc), .cfg_i(mem_cfg_i), .ok_o(rx_ok));

  // Strobes and flags: reset, one cycle long.
  always_ff @(posedge clk) begin
    if (rst) begin
      net_vld_o <= 1'b0;
      hwr_vld_o <= 1'b0;
      hwr_oor_o <= 1'b0;
      rx_vld_o  <= 1'b0;
      rx_oor_o  <= 1'b0;
      fwd_vld_o <= 1'b0;
    end else begin
      net_vld_o <= tx_req_i;
      hwr_vld_o <= tx_req_i && hwr_ok;
      hwr_oor_o <= tx_req_i && !hwr_ok;
      rx_vld_o  <= rx_req_i && rx_ok;
      rx_oor_o  <= rx_req_i && !rx_ok;
      fwd_vld_o <= fwd_req_i;
    end
  end

  // Address registers: loaded on accept, held otherwise, no reset.
  always_ff @(posedge clk) begin
    if (tx_req_i) begin
      net_addr_o <= tx_net;
      hwr_addr_o <= tx_addr_i;
    end
    if (rx_req_i)  rx_addr_o  <= rx_loc;
    if (fwd_req_i) fwd_addr_o <= fwd_addr_i;
  end

  assert_tx_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    tx_req_i |=> net_vld_o);

  assert_tx_low_bits_R4: assert property (@(posedge clk) disable iff (rst)
    net_vld_o |-> (net_addr_o[LW-1:0] == hwr_addr_o[LW-1:0]));

  assert_rx_undo_R5: assert property (@(posedge clk) disable iff (rst)
    rx_req_i |=> (NET_AW'(rx_addr_o + {$past(ofs_sel_i), {LW{1'b0}}}) == $past(rx_addr_i)));

  assert_fwd_pass_R6: assert property (@(posedge clk) disable iff (rst)
    fwd_req_i |=> (fwd_vld_o && fwd_addr_o == $past(fwd_addr_i)));

  assert_store_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(rx_vld_o && rx_oor_o) && !(hwr_vld_o && hwr_oor_o));

  assert_rsvd_cfg_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_req_i && cfg_is_reserved(mem_cfg_i)) |=> (rx_oor_o && !rx_vld_o));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !tx_req_i |=> (!net_vld_o && $stable(net_addr_o)));
endmodule

// File: tb/net_ofs_xlate_tb.sv
`timescale 1ns/1ps
module net_ofs_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  ofs_sel, mem_cfg;
  logic        tx_req, rx_req, fwd_req;
  logic [27:0] tx_addr, rx_addr, fwd_addr;
  logic        net_vld, hwr_vld, hwr_oor, rx_vld, rx_oor, fwd_vld;
  logic [27:0] net_addr, hwr_addr, rx_addr_q, fwd_addr_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  net_ofs_xlate dut_i (
    .clk(clk), .rst(rst), .ofs_sel_i(ofs_sel), .mem_cfg_i(mem_cfg),
    .tx_req_i(tx_req), .tx_addr_i(tx_addr),
    .rx_req_i(rx_req), .rx_addr_i(rx_addr),
    .fwd_req_i(fwd_req), .fwd_addr_i(fwd_addr),
    .net_vld_o(net_vld), .net_addr_o(net_addr),
    .hwr_vld_o(hwr_vld), .hwr_oor_o(hwr_oor), .hwr_addr_o(hwr_addr),
    .rx_vld_o(rx_vld), .rx_oor_o(rx_oor), .rx_addr_o(rx_addr_q),
    .fwd_vld_o(fwd_vld), .fwd_addr_o(fwd_addr_q));

  // kind: 0 = host write checked on network side, 1 = host write local side,
  //       2 = receive, 3 = forward
  typedef struct packed {
    logic [3:0]  req;
    logic [1:0]  kind;
    logic [1:0]  ofs;
    logic [1:0]  cfg;
    logic [27:0] addr;
    logic [27:0] exp;
    logic        vld;
    logic        oor;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 2'd0, 2'd0, 2'd2, 28'h0001234, 28'h0001234, 1'b1, 1'b0}, // R2
    '{4'd2, 2'd0, 2'd1, 2'd2, 28'h0001234, 28'h4001234, 1'b1, 1'b0}, // R2
    '{4'd2, 2'd0, 2'd2, 2'd2, 28'h0123456, 28'h8123456, 1'b1, 1'b0}, // R2
    '{4'd2, 2'd0, 2'd3, 2'd2, 28'h0000010, 28'hC000010, 1'b1, 1'b0}, // R2
    '{4'd3, 2'd0, 2'd1, 2'd2, 28'hFFFFFF0, 28'h3FFFFF0, 1'b1, 1'b0}, // R3
    '{4'd3, 2'd0, 2'd3, 2'd0, 28'h8000000, 28'h4000000, 1'b1, 1'b0}, // R3
    '{4'd4, 2'd1, 2'd3, 2'd2, 28'h0ABCDEF, 28'h0ABCDEF, 1'b1, 1'b0}, // R4
    '{4'd7, 2'd1, 2'd0, 2'd0, 28'h4000000, 28'h4000000, 1'b0, 1'b1}, // R7
    '{4'd7, 2'd1, 2'd0, 2'd0, 28'h3FFFFFF, 28'h3FFFFFF, 1'b1, 1'b0}, // R7
    '{4'd5, 2'd2, 2'd1, 2'd2, 28'h4001234, 28'h0001234, 1'b1, 1'b0}, // R5
    '{4'd5, 2'd2, 2'd2, 2'd2, 28'h0000100, 28'h8000100, 1'b1, 1'b0}, // R5
    '{4'd7, 2'd2, 2'd1, 2'd1, 28'hC000000, 28'h8000000, 1'b0, 1'b1}, // R7
    '{4'd7, 2'd2, 2'd1, 2'd1, 28'hBFFFFFF, 28'h7FFFFFF, 1'b1, 1'b0}, // R7
    '{4'd8, 2'd2, 2'd0, 2'd3, 28'h0000000, 28'h0000000, 1'b0, 1'b1}, // R8
    '{4'd8, 2'd1, 2'd2, 2'd3, 28'h0000040, 28'h0000040, 1'b0, 1'b1}, // R8
    '{4'd6, 2'd3, 2'd3, 2'd3, 28'h1234567, 28'h1234567, 1'b1, 1'b0}  // R6
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    tx_req = 1'b0; rx_req = 1'b0; fwd_req = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    string tag;
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    ofs_sel = v.ofs; mem_cfg = v.cfg;
    case (v.kind)
      2'd0, 2'd1: begin tx_req = 1'b1; tx_addr = v.addr; end
      2'd2:       begin rx_req = 1'b1; rx_addr = v.addr; end
      default:    begin fwd_req = 1'b1; fwd_addr = v.addr; end
    endcase
    @(negedge clk);
    case (v.kind)
      2'd0: begin
        chk(tag, "net_addr", 32'(net_addr), 32'(v.exp));
        chk(tag, "net_vld", 32'(net_vld), 32'(v.vld));
      end
      2'd1: begin
        chk(tag, "hwr_addr", 32'(hwr_addr), 32'(v.exp));
        chk(tag, "hwr_vld/oor", 32'({hwr_vld, hwr_oor}), 32'({v.vld, v.oor}));
      end
      2'd2: begin
        if (v.vld) chk(tag, "rx_addr", 32'(rx_addr_q), 32'(v.exp));
        chk(tag, "rx_vld/oor", 32'({rx_vld, rx_oor}), 32'({v.vld, v.oor}));
      end
      default: begin
        chk(tag, "fwd_addr", 32'(fwd_addr_q), 32'(v.exp));
        chk(tag, "fwd_vld", 32'(fwd_vld), 32'(v.vld));
      end
    endcase
    idle_inputs();
  endtask

  initial begin : watchdog
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [27:0] sent;
    rst = 1'b1; ofs_sel = 2'd0; mem_cfg = 2'd2;
    tx_addr = '0; rx_addr = '0; fwd_addr = '0;
    // R1: requests held high during reset must not produce strobes
    tx_req = 1'b1; rx_req = 1'b1; fwd_req = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "strobes in reset", 32'({net_vld, hwr_vld, hwr_oor, rx_vld, rx_oor, fwd_vld}), 32'd0);
    idle_inputs();
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "strobes after reset", 32'({net_vld, hwr_vld, hwr_oor, rx_vld, rx_oor, fwd_vld}), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: output holds and strobe falls when offset changes without request
    @(negedge clk);
    ofs_sel = 2'd1; mem_cfg = 2'd2; tx_req = 1'b1; tx_addr = 28'h0000010;
    @(negedge clk);
    chk("R9", "net_addr on accept", 32'(net_addr), 32'h4000010);
    idle_inputs(); ofs_sel = 2'd2;
    @(negedge clk);
    chk("R9", "net_addr held", 32'(net_addr), 32'h4000010);
    chk("R9", "net_vld low", 32'(net_vld), 32'd0);

    // R10: transmit then receive with the same offset
    @(negedge clk);
    ofs_sel = 2'd2; tx_req = 1'b1; tx_addr = 28'h0765432;
    @(negedge clk);
    sent = net_addr;
    idle_inputs();
    @(negedge clk);
    rx_req = 1'b1; rx_addr = sent;
    @(negedge clk);
    chk("R10", "round trip", 32'(rx_addr_q), 32'h0765432);
    chk("R10", "round trip vld", 32'(rx_vld), 32'd1);
    idle_inputs();

    // R11: all three requests in one cycle
    @(negedge clk);
    ofs_sel = 2'd3; mem_cfg = 2'd2;
    tx_req = 1'b1;  tx_addr  = 28'h0000111;
    rx_req = 1'b1;  rx_addr  = 28'hC000222;
    fwd_req = 1'b1; fwd_addr = 28'h5555555;
    @(negedge clk);
    chk("R11", "net_addr", 32'(net_addr), 32'hC000111);
    chk("R11", "rx_addr", 32'(rx_addr_q), 32'h0000222);
    chk("R11", "fwd_addr", 32'(fwd_addr_q), 32'h5555555);
    chk("R11", "strobes", 32'({net_vld, hwr_vld, rx_vld, fwd_vld}), 32'hF);
    idle_inputs();
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule